// File: doc/BRIEF.md
# Host Control/Status Register Bank with Alternating Identification Signature

This block is a 32-bit control/status register bank on a simple host bus. The host presents a long-word address, a read or write strobe, four byte enables and write data. The block returns registered read data with an acknowledge one cycle later. When the host flags an access as the first beat of a burst, the block serves only that beat and then raises a stop indication. It does not transfer any further beats of that burst.

The map holds the following registers:

- A bus-control word at word 0.
- A transmit-demand strobe location at word 1. Writing it pulses an output to the transmit engine.
- Six scratch words, at words 2, 3, 14, 15, 17 and 18.
- An identification word at word 16.

The upper half of the identification word can be written by the driver. Its low byte alternates between two constants on successive reads, which lets software recognise the hardware.

A synchronous soft-reset input clears most of the state. It spares bit 0 of bus-control and the words at 14, 15, 16, 17 and 18. It also spares the signature read-parity state, which only the hardware reset clears.

Top module: `csr_ident_bank`

## Requirements
- R1: A write changes only the bytes whose enable is set; byte enable bit k covers data bits 8k+7:8k, and a read of a mapped scratch or bus-control word returns the stored value.
- R2: An accepted read or write is acknowledged exactly one cycle after its strobe, and read data is valid in that acknowledge cycle.
- R3: In the identification word (word 16), bits 31:16 are read/write by the host and bits 15:8 always read as zero.
- R4: Bits 7:0 of the identification word read 12h on odd-numbered reads and 9Ah on even-numbered reads, counted from hardware reset. Every completed read of word 16 advances the count, whatever its byte enables.
- R5: Reading any unmapped word returns zero, and writing one changes no register.
- R6: If an accepted access has the burst flag set, stop is high for exactly the one cycle after its acknowledge. Strobes presented during the acknowledge cycle and the stop cycle are neither acknowledged nor performed.
- R7: Soft reset clears bus-control bits 31:1 and scratch words 2 and 3. It leaves the following unchanged:
  - bus-control bit 0;
  - words 14, 15, 17 and 18;
  - identification bits 31:16;
  - the signature alternation.
- R8: A write to word 1 raises the transmit-demand output for exactly one cycle, together with its acknowledge. A read of word 1 returns zero.
- R9: Hardware reset clears every register and output, and it restarts the signature sequence at 12h.
- R10: When read and write strobes are both high, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst_n | input | 1 | Synchronous active-low soft reset |
| bus_addr | input | AW (6) | Long-word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_burst | input | 1 | Access is the first beat of a multi-beat burst |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ack | output | 1 | Access completed |
| bus_stop | output | 1 | Burst termination, no data |
| tx_demand | output | 1 | One-cycle transmit-demand pulse |

## Verification
The hardest state to reach from the ports is one where soft reset must be shown to have spared both data and the signature parity. Reaching it requires every exempt and non-exempt word to hold distinct non-zero values, and an odd number of identification reads to have occurred before the soft reset. The stimulus fills every word with its own pattern, reads the identification word an odd number of times, pulses soft reset, and then reads the whole map. The next signature must continue the alternation rather than restart. Bursts are driven by holding the strobe and changing the write data through the acknowledge cycle. This shows the second beat reaches no register.

// File: rtl/csr_ident_pkg.sv
// Package: shared constants and map helpers for the identification register bank.
// Assumes a 32-bit data path and long-word addressing.
package csr_ident_pkg;

    localparam int DW      = 32;
    localparam int NB      = DW / 8;
    localparam int W_BCTL  = 0;
    localparam int W_TXD   = 1;
    localparam int W_IDENT = 16;
    localparam int NUM_SCR = 6;

    localparam logic [7:0]    SIG_ODD   = 8'h12;
    localparam logic [7:0]    SIG_EVEN  = 8'h9A;
    localparam logic [DW-1:0] BCTL_KEEP = 32'h0000_0001;

    // Word index of scratch register i.
    function automatic int scr_word(int i);
        case (i)
            0:       return 2;
            1:       return 3;
            2:       return 14;
            3:       return 15;
            4:       return 17;
            default: return 18;
        endcase
    endfunction

    // Scratch register i survives soft reset.
    function automatic bit scr_keep(int i);
        return (i >= 2);
    endfunction

    // A word index belongs to the register map.
    function automatic bit is_mapped(int w);
        bit hit;
        hit = (w == W_BCTL) || (w == W_TXD) || (w == W_IDENT);
        for (int i = 0; i < NUM_SCR; i++)
            if (w == scr_word(i)) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/csr_bus_front.sv
// Module: bus front end. Qualifies strobes into single accesses, produces the
// acknowledge one cycle later and cuts bursts after the first beat.
// Assumes strobes are sampled every cycle; read wins over write.
module csr_bus_front (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_burst,
    output logic acc_rd,
    output logic acc_wr,
    output logic bus_ack,
    output logic bus_stop
);

    logic ack_q;
    logic stop_pend_q;
    logic stop_q;
    logic busy;

    // Block new accesses while a burst is being terminated.
    assign busy   = stop_pend_q | stop_q;
    assign acc_rd = bus_rd & ~busy;
    assign acc_wr = bus_wr & ~bus_rd & ~busy;

    // Acknowledge and stop sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            stop_q      <= 1'b0;
        end else begin
            ack_q       <= acc_rd | acc_wr;
            stop_pend_q <= (acc_rd | acc_wr) & bus_burst;
            stop_q      <= stop_pend_q;
        end
    end

    assign bus_ack  = ack_q;
    assign bus_stop = stop_q;

endmodule

// File: rtl/csr_word_reg.sv
// Module: byte-enabled storage word with a soft-reset mask.
// Bits set in SOFT_MASK return to RST_VAL on soft clear; others keep their value.
// Soft clear takes priority over a write in the same cycle.
module csr_word_reg #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RST_VAL   = '0,
    parameter logic [WIDTH-1:0] SOFT_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               we,
    input  logic [WIDTH/8-1:0] be,
    input  logic [WIDTH-1:0]   wdata,
    output logic [WIDTH-1:0]   q
);

    localparam int LANES = WIDTH / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane: reset, masked soft clear, enabled write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
            else if (soft_clr)
                q[g*8 +: 8] <= (q[g*8 +: 8] & ~SOFT_MASK[g*8 +: 8])
                             | (RST_VAL[g*8 +: 8] & SOFT_MASK[g*8 +: 8]);
            else if (we && be[g])
                q[g*8 +: 8] <= wdata[g*8 +: 8];
        end
    end

endmodule

// File: rtl/csr_sig_gen.sv
// Module: signature byte generator. Holds the read parity of the identification
// word; advances on each completed read of it. Only hardware reset clears it.
module csr_sig_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_hit,
    output logic [7:0] sig_byte
);

    import csr_ident_pkg::*;

    logic par_q;

    // Toggle parity once per identification read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            par_q <= 1'b0;
        else if (rd_hit)
            par_q <= ~par_q;
    end

    assign sig_byte = par_q ? SIG_EVEN : SIG_ODD;

endmodule

// File: rtl/csr_ident_bank.sv
// Module: top of the register bank. Decodes word addresses, holds the map,
// muxes read data into a register and drives the transmit-demand pulse.
// Assumes AW >= 5 so every mapped word index is addressable.
module csr_ident_bank #(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_burst,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        bus_stop,
    output logic        tx_demand
);

    import csr_ident_pkg::*;

    localparam int HALF = DW / 2;

    logic          acc_rd;
    logic          acc_wr;
    logic          soft_clr;
    logic          sel_bctl;
    logic          sel_txd;
    logic          sel_ident;
    logic [DW-1:0] bctl_q;
    logic [HALF-1:0] ident_hi_q;
    logic [7:0]    sig_byte;
    logic [DW-1:0] scr_q [NUM_SCR];
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    logic          tx_q;

    assign soft_clr  = ~soft_rst_n;
    assign sel_bctl  = (bus_addr == AW'(W_BCTL));
    assign sel_txd   = (bus_addr == AW'(W_TXD));
    assign sel_ident = (bus_addr == AW'(W_IDENT));

    csr_bus_front i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_burst(bus_burst),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .bus_ack  (bus_ack),
        .bus_stop (bus_stop)
    );

    csr_word_reg #(
        .WIDTH    (DW),
        .RST_VAL  ('0),
        .SOFT_MASK(~BCTL_KEEP)
    ) i_bctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_clr),
        .we      (acc_wr && sel_bctl),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .q       (bctl_q)
    );

    csr_word_reg #(
        .WIDTH    (HALF),
        .RST_VAL  ('0),
        .SOFT_MASK('0)
    ) i_ident_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(soft_clr),
        .we      (acc_wr && sel_ident),
        .be      (bus_be[NB-1:NB/2]),
        .wdata   (bus_wdata[DW-1:HALF]),
        .q       (ident_hi_q)
    );

    for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
        localparam logic [DW-1:0] MASK = scr_keep(i) ? '0 : '1;
        logic sel;
        assign sel = (bus_addr == AW'(scr_word(i)));
        csr_word_reg #(
            .WIDTH    (DW),
            .RST_VAL  ('0),
            .SOFT_MASK(MASK)
        ) i_scr (
            .clk     (clk),
            .rst_n   (rst_n),
            .soft_clr(soft_clr),
            .we      (acc_wr && sel),
            .be      (bus_be),
            .wdata   (bus_wdata),
            .q       (scr_q[i])
        );
    end

    csr_sig_gen i_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hit  (acc_rd && sel_ident),
        .sig_byte(sig_byte)
    );

    // Read-data selection; unmapped words and the strobe word read zero.
    always_comb begin
        rd_mux = '0;
        if (sel_bctl)
            rd_mux = bctl_q;
        else if (sel_ident)
            rd_mux = {ident_hi_q, 8'h00, sig_byte};
        for (int i = 0; i < NUM_SCR; i++)
            if (bus_addr == AW'(scr_word(i)))
                rd_mux = scr_q[i];
    end

    // Register read data and the transmit-demand pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            tx_q    <= 1'b0;
        end else begin
            rdata_q <= acc_rd ? rd_mux : '0;
            tx_q    <= acc_wr && sel_txd;
        end
    end

    assign bus_rdata = rdata_q;
    assign tx_demand = tx_q;

endmodule

// File: rtl/csr_ident_bank_chk.sv
// Module: protocol checker for csr_ident_bank, bound to every instance.
// Observes ports only.
module csr_ident_bank_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [31:0]   bus_rdata,
    input logic          bus_ack,
    input logic          bus_stop,
    input logic          tx_demand
);

    import csr_ident_pkg::*;

    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_rd || bus_wr));

    // R6
    stop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |-> ($past(bus_ack) && !bus_ack));

    // R6
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!bus_stop && !bus_ack));

    // R8
    tx_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_demand |-> (bus_ack && $past(bus_wr) && !$past(bus_rd)
                       && ($past(bus_addr) == AW'(W_TXD))));

    // R3
    sig_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_rd) && ($past(bus_addr) == AW'(W_IDENT)))
        |-> (bus_rdata[15:8] == 8'h00
             && (bus_rdata[7:0] == SIG_ODD || bus_rdata[7:0] == SIG_EVEN)));

    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_rd) && !is_mapped(int'($past(bus_addr))))
        |-> (bus_rdata == 32'h0));

endmodule

bind csr_ident_bank csr_ident_bank_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack),
    .bus_stop (bus_stop),
    .tx_demand(tx_demand)
);

// File: tb/test_csr_ident_bank.sv
// Scoreboard bench: access tasks queue expected results, a monitor pops them on ack.
module test_csr_ident_bank;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst_n;
    logic [5:0]  bus_addr;
    logic        bus_rd, bus_wr, bus_burst;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_stop, tx_demand;

    always #5 clk = ~clk;

    csr_ident_bank i_csr_ident_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_burst(bus_burst), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_stop(bus_stop),
        .tx_demand(tx_demand)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       req;
        logic [7:0]  ofs;
    } item_t;

    item_t       sbq[$];
    logic [31:0] mdl [int];
    bit          mpar;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function void mdl_reset();
        mdl.delete();
        foreach (MAP_OFS[k]) mdl[MAP_OFS[k]] = 32'h0;
        mpar = 1'b0;
    endfunction

    localparam int MAP_OFS [9] = '{'h00, 'h04, 'h08, 'h0C, 'h38, 'h3C, 'h40, 'h44, 'h48};

    function void mdl_write(logic [7:0] o, logic [3:0] be, logic [31:0] d);
        logic [31:0] t;
        if (!mdl.exists(int'(o)) || o == 8'h04) return;
        t = mdl[int'(o)];
        for (int b = 0; b < 4; b++)
            if (be[b] && (o != 8'h40 || b >= 2)) t[b*8 +: 8] = d[b*8 +: 8];
        mdl[int'(o)] = t;
    endfunction

    function logic [31:0] exp_read(logic [7:0] o);
        logic [31:0] r;
        if (o == 8'h40) begin
            r = {mdl['h40][31:16], 8'h00, mpar ? 8'h9A : 8'h12};
            mpar = ~mpar;
        end else if (o == 8'h04 || !mdl.exists(int'(o)))
            r = 32'h0;
        else
            r = mdl[int'(o)];
        return r;
    endfunction

    // Monitor: compare every acknowledged access against the queue.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && bus_ack) begin
            if (sbq.size() == 0)
                chk(1'b0, "R2", 32'h1, 32'h0, "ack with no access queued");
            else begin
                it = sbq.pop_front();
                if (it.is_rd)
                    chk(bus_rdata == it.exp, it.req, bus_rdata, it.exp,
                        $sformatf("read of %h", it.ofs));
            end
        end
    end

    task automatic idle_bus();
        bus_rd = 0; bus_wr = 0; bus_burst = 0; bus_be = 4'h0; bus_wdata = '0;
    endtask

    task automatic wr(logic [7:0] o, logic [3:0] be, logic [31:0] d, string req);
        @(negedge clk);
        bus_addr = o[7:2]; bus_wr = 1; bus_be = be; bus_wdata = d;
        sbq.push_back('{1'b0, 32'h0, req, o});
        mdl_write(o, be, d);
        @(negedge clk);
        idle_bus();
        // R8: pulse coincides with the acknowledge of a strobe-word write only
        chk(tx_demand == (o == 8'h04), "R8", {31'h0, tx_demand}, {31'h0, o == 8'h04}, "tx_demand in ack cycle");
        if (o == 8'h04) begin
            @(negedge clk);
            chk(tx_demand == 1'b0, "R8", {31'h0, tx_demand}, 32'h0, "tx_demand one cycle later");
        end
    endtask

    task automatic rd(logic [7:0] o, logic [3:0] be, string req);
        @(negedge clk);
        bus_addr = o[7:2]; bus_rd = 1; bus_be = be;
        sbq.push_back('{1'b1, exp_read(o), req, o});
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd_all(string req);
        foreach (MAP_OFS[k]) rd(8'(MAP_OFS[k]), 4'hF, req);
    endtask

    task automatic burst(bit is_read, logic [7:0] o, logic [31:0] d1, logic [31:0] d2);
        @(negedge clk);
        bus_addr = o[7:2]; bus_burst = 1; bus_be = 4'hF; bus_wdata = d1;
        if (is_read) begin
            bus_rd = 1;
            sbq.push_back('{1'b1, exp_read(o), "R6", o});
        end else begin
            bus_wr = 1;
            sbq.push_back('{1'b0, 32'h0, "R6", o});
            mdl_write(o, 4'hF, d1);
        end
        @(negedge clk);
        bus_wdata = d2;                       // second beat held through ack cycle
        chk(bus_stop == 1'b0, "R6", {31'h0, bus_stop}, 32'h0, "stop in ack cycle");
        @(negedge clk);
        chk(bus_stop == 1'b1, "R6", {31'h0, bus_stop}, 32'h1, "stop after ack");
        chk(bus_ack == 1'b0, "R6", {31'h0, bus_ack}, 32'h0, "no second beat ack");
        idle_bus();
        @(negedge clk);
        chk(bus_stop == 1'b0, "R6", {31'h0, bus_stop}, 32'h0, "stop lasts one cycle");
        chk(bus_ack == 1'b0, "R6", {31'h0, bus_ack}, 32'h0, "no ack for stop-cycle strobe");
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 0; idle_bus();
        repeat (2) @(negedge clk);
        sbq.delete();
        // R9: outputs cleared while in reset
        chk({bus_ack, bus_stop, tx_demand} == 3'b0, "R9", {29'h0, bus_ack, bus_stop, tx_demand}, 32'h0, "control outputs in reset");
        chk(bus_rdata == 32'h0, "R9", bus_rdata, 32'h0, "rdata in reset");
        rst_n = 1;
        mdl_reset();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; soft_rst_n = 1; bus_addr = '0; idle_bus();
        repeat (3) @(negedge clk);
        hw_reset();

        // R9: all registers zero, signature starts at 12h
        rd_all("R9");

        // R1: byte-enable writes
        wr(8'h00, 4'hF, 32'hDEAD_BEEF, "R1");
        rd(8'h00, 4'hF, "R1");
        wr(8'h00, 4'b0101, 32'h1122_3344, "R1");
        rd(8'h00, 4'hF, "R1");
        wr(8'h08, 4'b0000, 32'hFFFF_FFFF, "R1");
        rd(8'h08, 4'hF, "R1");
        wr(8'h38, 4'b1110, 32'hA5A5_5A5A, "R1");
        rd(8'h38, 4'hF, "R1");

        // R3: upper half writable, middle byte zero
        wr(8'h40, 4'hF, 32'hFFFF_FFFF, "R3");
        rd(8'h40, 4'hF, "R3");
        wr(8'h40, 4'b0100, 32'h0012_3400, "R3");
        rd(8'h40, 4'hF, "R3");

        // R4: alternation advances for any byte enables
        rd(8'h40, 4'b0000, "R4");
        rd(8'h40, 4'b0001, "R4");
        rd(8'h40, 4'b1000, "R4");

        // R5: unmapped words
        wr(8'h10, 4'hF, 32'hFFFF_FFFF, "R5");
        wr(8'h4C, 4'hF, 32'hFFFF_FFFF, "R5");
        wr(8'hFC, 4'hF, 32'hFFFF_FFFF, "R5");
        rd(8'h10, 4'hF, "R5");
        rd(8'h4C, 4'hF, "R5");
        rd(8'hFC, 4'hF, "R5");
        rd_all("R5");

        // R6: burst termination for write and read
        burst(1'b0, 8'h0C, 32'h0BAD_F00D, 32'hFFFF_0000);
        rd(8'h0C, 4'hF, "R6");
        wr(8'h44, 4'hF, 32'h4444_4444, "R6");
        burst(1'b1, 8'h44, 32'h0, 32'h0);

        // R8: transmit demand
        wr(8'h04, 4'hF, 32'hFFFF_FFFF, "R8");
        rd(8'h04, 4'hF, "R8");

        // R10: read wins over a simultaneous write
        @(negedge clk);
        bus_addr = 6'h03; bus_rd = 1; bus_wr = 1; bus_be = 4'hF; bus_wdata = 32'h7777_7777;
        sbq.push_back('{1'b1, exp_read(8'h0C), "R10", 8'h0C});
        @(negedge clk);
        idle_bus();
        rd(8'h0C, 4'hF, "R10");

        // R7: soft reset exemptions, signature parity kept
        wr(8'h00, 4'hF, 32'hFFFF_FFFF, "R7");
        wr(8'h08, 4'hF, 32'h0808_0808, "R7");
        wr(8'h0C, 4'hF, 32'h0C0C_0C0C, "R7");
        wr(8'h38, 4'hF, 32'h3838_3838, "R7");
        wr(8'h3C, 4'hF, 32'h3C3C_3C3C, "R7");
        wr(8'h40, 4'hF, 32'h4040_0000, "R7");
        wr(8'h44, 4'hF, 32'h4444_4444, "R7");
        wr(8'h48, 4'hF, 32'h4848_4848, "R7");
        if (!mpar) rd(8'h40, 4'hF, "R7");    // leave parity on the even side
        @(negedge clk);
        soft_rst_n = 0;
        @(negedge clk);
        soft_rst_n = 1;
        mdl['h00] = mdl['h00] & 32'h1;
        mdl['h08] = 32'h0;
        mdl['h0C] = 32'h0;
        rd_all("R7");

        // R9: hardware reset restarts everything
        hw_reset();
        rd(8'h40, 4'hF, "R9");
        rd(8'h38, 4'hF, "R9");
        rd(8'h00, 4'hF, "R9");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R2", 32'(sbq.size()), 32'h0, "accesses left unacknowledged");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule